// File: doc/BRIEF.md
# Shared Interrupt Pin to Legacy Line Router

This block steers a set of shared, level-sensitive interrupt pins onto sixteen legacy interrupt lines. Device sources raise level requests, and each source is wired at build time to one pin or to none. A pin counts as active while at least one of its sources holds its level high, so several devices can share a pin and it stays up until the last of them lets go.

Each pin has an 8-bit routing register that software reaches through a small register port. The register holds a suppress flag and a 4-bit target line number. A fixed permission mask marks which line numbers are usable. A pin whose register selects a line outside that mask is treated exactly like a suppressed pin. Every legacy line is driven from a flop and is the OR of all pins that are active, unsuppressed, permitted and aimed at that line.

When software reprograms a register while its pin is active, the asserted level moves from the old line to the new line in the same clock step. A register write and a change in source levels that arrive in the same cycle are combined into one update, so no line shows a transient pulse.

Top module: `irq_pin_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, every routing register becomes 0x80 (suppressed, line 0) and `irq_out` becomes all zero.
- R2: A write stores only bit 7 (suppress flag) and bits 3:0 (target line) of `reg_wdata`. Bits 6:4 read back as zero. `reg_rdata` shows the stored value of the pin selected by `reg_addr` without waiting for a clock edge.
- R3: A pin is active while any source mapped to it has its level high. It stays active until every such source is low.
- R4: One clock edge after the inputs are applied, `irq_out[k]` is high exactly when some pin is active, has bit 7 clear, has a permitted target, and has bits 3:0 equal to k.
- R5: A pin with bit 7 set contributes to no line, whatever its target field holds.
- R6: Only target values 3 to 7, 9 to 12, 14 and 15 are permitted (mask 0xDEF8). A pin that selects 0, 1, 2, 8 or 13 contributes to no line, just as if it were suppressed.
- R7: Rewriting the register of an active pin moves its level from the old line to the new line at the same edge. No cycle shows both lines asserted.
- R8: Writing the value a register already holds changes neither the register nor any line.
- R9: A source whose map entry is 0 affects no pin and no line.
- R10: A register write and a source level change in the same cycle show up together in `irq_out` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Pin selected for the register read or write |
| reg_we | input | 1 | Write strobe for the selected pin's register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Stored register of the selected pin (combinational) |
| src_level | input | 12 | Level request from each device source |
| irq_out | output | 16 | Registered legacy interrupt lines |

## Verification
The assertions assume that `reg_addr` always selects an existing pin and that the source-to-pin map only names pins that exist or 0. The stimulus keeps to this: every address it drives lies below the pin count, and it uses the default map unchanged. Inputs change only on the falling edge, so every write and level change is sampled at one clear rising edge. The random phase still writes arbitrary bytes, so reserved targets, set pad bits and repeated values all occur.

// File: rtl/irq_router_pkg.sv
// Package: shared constants and helpers for the interrupt pin router.
// Assumes an 8-bit routing register with a suppress flag in bit 7 and a
// 4-bit target line field in bits 3:0.
package irq_router_pkg;

    localparam int ROUTE_W   = 8;
    localparam int FIELD_W   = 4;
    localparam int NUM_LINES = 1 << FIELD_W;

    typedef logic [ROUTE_W-1:0] route_t;

    localparam route_t ROUTE_RESET = 8'h80;
    localparam route_t ROUTE_KEEP  = 8'h8F;
    localparam int     SUPPRESS_BIT = 7;

    // Route contributes only when unsuppressed and its target is permitted.
    function automatic logic route_ok(input route_t r, input logic [NUM_LINES-1:0] mask);
        return (!r[SUPPRESS_BIT]) && mask[r[FIELD_W-1:0]];
    endfunction

endpackage

// File: rtl/irq_src_counter.sv
// Module: irq_src_counter
// Counts, for every pin, how many mapped device sources are requesting,
// and reports a pin as active while that count is non-zero.
// Assumes each map entry is 0 (unrouted) or a 1-based pin number.
module irq_src_counter #(
    parameter int NUM_PINS = 8,
    parameter int NUM_SRC  = 12,
    parameter int PIDX_W   = $clog2(NUM_PINS + 1),
    parameter logic [NUM_SRC*PIDX_W-1:0] SRC_PIN_MAP = '0
) (
    input  logic [NUM_SRC-1:0]  src_level,
    output logic [NUM_PINS-1:0] pin_active
);

    localparam int CNT_W = $clog2(NUM_SRC + 1);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [CNT_W-1:0] cnt;

        // Sum the requesting sources that are wired to this pin.
        always_comb begin
            cnt = '0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (src_level[s] &&
                    SRC_PIN_MAP[s*PIDX_W +: PIDX_W] == PIDX_W'(p + 1)) begin
                    cnt = cnt + CNT_W'(1);
                end
            end
        end

        assign pin_active[p] = (cnt != '0);
    end

    // R3/R9: with no source requesting, no pin may be active.
    always_comb begin
        a_r3_idle_sources: assert (!((src_level == '0) && (pin_active != '0)));
    end

endmodule

// File: rtl/irq_route_regs.sv
// Module: irq_route_regs
// Holds one routing register per pin, written and read through a small
// port. Only the suppress flag and target field are kept. Also exports
// the value the registers will take at the next edge, so that the line
// logic can fold a write into the same step.
// Assumes reg_addr selects an existing pin.
module irq_route_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_we,
    input  logic [ROUTE_W-1:0]        reg_wdata,
    output logic [ROUTE_W-1:0]        reg_rdata,
    output logic [NUM_PINS-1:0][ROUTE_W-1:0] route_q,
    output logic [NUM_PINS-1:0][ROUTE_W-1:0] route_nxt
);

    logic addr_ok;
    assign addr_ok = (int'(reg_addr) < NUM_PINS);

    // Next register state: the current state with any masked write applied.
    always_comb begin
        route_nxt = route_q;
        if (reg_we && addr_ok) begin
            route_nxt[reg_addr] = reg_wdata & ROUTE_KEEP;
        end
    end

    // Register bank with synchronous active-low reset to the suppressed value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                route_q[p] <= ROUTE_RESET;
            end
        end else begin
            route_q <= route_nxt;
        end
    end

    // Combinational read of the addressed pin.
    assign reg_rdata = addr_ok ? route_q[reg_addr] : '0;

    // R8: rewriting the held value leaves the bank unchanged.
    a_r8_same_value_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && addr_ok && ((reg_wdata & ROUTE_KEEP) == route_q[reg_addr]))
        |=> $stable(route_q));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        // R2: pad bits never hold ones.
        a_r2_pad_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
            route_q[p][6:4] == 3'b000);
        // R1: a reset edge leaves the register suppressed.
        a_r1_reset_value: assert property (@(posedge clk)
            (rst_n && !$past(rst_n)) |-> route_q[p] == ROUTE_RESET);
    end

endmodule

// File: rtl/irq_line_merge.sv
// Module: irq_line_merge
// Decodes each pin's route into a one-hot line request, ORs the requests
// of all pins and registers the result as the legacy line outputs.
// Assumes route and pin_active describe the state after this cycle's edge.
module irq_line_merge
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter logic [NUM_LINES-1:0] PERMIT_MASK = 16'hDEF8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PINS-1:0][ROUTE_W-1:0] route,
    input  logic [NUM_PINS-1:0]              pin_active,
    output logic [NUM_LINES-1:0]             irq_out
);

    logic [NUM_LINES-1:0] lines_nxt;
    logic [NUM_PINS-1:0]  pin_live;

    // Per pin: active and carrying a usable route.
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            pin_live[p] = pin_active[p] && route_ok(route[p], PERMIT_MASK);
        end
    end

    // OR of every live pin's target line.
    always_comb begin
        lines_nxt = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (pin_live[p]) begin
                lines_nxt[route[p][FIELD_W-1:0]] = 1'b1;
            end
        end
    end

    // Output flops with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out <= '0;
        end else begin
            irq_out <= lines_nxt;
        end
    end

    // R4: no active pin means every line drops at the next edge.
    a_r4_idle_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_active == '0) |=> (irq_out == '0));

    // R7: a line is never raised by more distinct lines than there are pins.
    a_r7_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_out) <= NUM_PINS);

    // R6: reserved lines never assert.
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        if (!PERMIT_MASK[k]) begin : g_rsv
            a_r6_reserved_line_low: assert property (@(posedge clk) disable iff (!rst_n)
                !irq_out[k]);
        end
    end

endmodule

// File: rtl/irq_pin_router.sv
// Module: irq_pin_router (top)
// Routes shared, level-sensitive interrupt pins onto legacy lines under
// per-pin routing registers and a fixed permission mask.
// Assumes SRC_PIN_MAP entries are 0 or 1..NUM_PINS.
module irq_pin_router
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int NUM_SRC  = 12,
    parameter int PIDX_W   = $clog2(NUM_PINS + 1),
    parameter logic [NUM_SRC*PIDX_W-1:0] SRC_PIN_MAP = 48'h2088_7654_3211,
    parameter logic [15:0] PERMIT_MASK = 16'hDEF8,
    parameter int ADDR_W   = $clog2(NUM_PINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [NUM_SRC-1:0] src_level,
    output logic [15:0]        irq_out
);

    logic [NUM_PINS-1:0][ROUTE_W-1:0] route_q;
    logic [NUM_PINS-1:0][ROUTE_W-1:0] route_nxt;
    logic [NUM_PINS-1:0]              pin_active;

    irq_route_regs #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .route_q   (route_q),
        .route_nxt (route_nxt)
    );

    irq_src_counter #(
        .NUM_PINS    (NUM_PINS),
        .NUM_SRC     (NUM_SRC),
        .PIDX_W      (PIDX_W),
        .SRC_PIN_MAP (SRC_PIN_MAP)
    ) u_count (
        .src_level  (src_level),
        .pin_active (pin_active)
    );

    // Line logic sees the post-write routes so writes and levels merge (R10).
    irq_line_merge #(
        .NUM_PINS    (NUM_PINS),
        .PERMIT_MASK (PERMIT_MASK)
    ) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .route      (route_nxt),
        .pin_active (pin_active),
        .irq_out    (irq_out)
    );

endmodule

// File: tb/irq_pin_router_test.sv
`timescale 1ns/1ps
module irq_pin_router_test;

    localparam logic [47:0] MAP  = 48'h2088_7654_3211;
    localparam logic [15:0] MASK = 16'hDEF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [11:0] src_level = '0;
    logic [15:0] irq_out;

    int checks = 0;
    int bad = 0;
    logic [7:0] mdl [8];

    always #5 clk = ~clk;

    irq_pin_router uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_level(src_level), .irq_out(irq_out)
    );

    // Expected lines from model registers and source levels.
    function automatic logic [15:0] expect_lines(input logic [11:0] s);
        logic [15:0] e = '0;
        for (int p = 0; p < 8; p++) begin
            logic act = 1'b0;
            for (int i = 0; i < 12; i++) begin
                if (s[i] && MAP[i*4 +: 4] == 4'(p + 1)) act = 1'b1;
            end
            if (act && !mdl[p][7] && MASK[mdl[p][3:0]]) e[mdl[p][3:0]] = 1'b1;
        end
        return e;
    endfunction

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // One cycle: apply inputs at negedge, compare after the rising edge.
    task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d,
                        input logic [11:0] s, input string req);
        logic [15:0] e;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; src_level = s;
        if (we) mdl[a] = d & 8'h8F;
        e = expect_lines(s);
        @(posedge clk); #1;
        check(irq_out, e, req);
        check({8'h00, reg_rdata}, {8'h00, mdl[a]}, "R2 readback");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired got=hung exp=done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < 8; p++) mdl[p] = 8'h80;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        check(irq_out, 16'h0000, "R1 lines");
        for (int p = 0; p < 8; p++) begin
            reg_addr = 3'(p); #1;
            check({8'h00, reg_rdata}, 16'h0080, "R1 register");
        end
        // R2/R5: pad bits dropped, suppressed pin silent
        step(1'b1, 3'd0, 8'hF5, 12'h001, "R5 suppressed");
        // R4: route pin A to line 5
        step(1'b1, 3'd0, 8'h05, 12'h001, "R4 route line5");
        // R3: shared sources keep the pin active
        step(1'b0, 3'd0, 8'h00, 12'h003, "R3 two sources");
        step(1'b0, 3'd0, 8'h00, 12'h002, "R3 one left");
        step(1'b0, 3'd0, 8'h00, 12'h000, "R3 all released");
        // R6: reserved targets behave as suppressed
        step(1'b1, 3'd0, 8'h08, 12'h002, "R6 target8");
        step(1'b1, 3'd0, 8'h0D, 12'h002, "R6 target13");
        step(1'b1, 3'd0, 8'h02, 12'h002, "R6 target2");
        // R7: live move from line 5 to line 9
        step(1'b1, 3'd0, 8'h05, 12'h002, "R7 before move");
        step(1'b1, 3'd0, 8'h09, 12'h002, "R7 after move");
        check(irq_out, 16'h0200, "R7 only new line");
        // R8: same-value write
        step(1'b1, 3'd0, 8'h09, 12'h002, "R8 same value");
        check(irq_out, 16'h0200, "R8 line kept");
        // R9: unrouted source
        step(1'b0, 3'd0, 8'h00, 12'h400, "R9 unrouted");
        check(irq_out, 16'h0000, "R9 no line");
        // R10: write and level in one cycle
        step(1'b1, 3'd7, 8'h0E, 12'h100, "R10 joint update");
        check(irq_out, 16'h4000, "R10 line14");
        // Random phase
        void'($urandom(32'd1234));
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] r = $urandom();
            step(r[1:0] == 2'b00, r[4:2], r[12:5], r[24:13], "R4 random");
        end
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule